// File: doc/BRIEF.md
# Byte ALU with Status Flag Update

This block is the arithmetic and logic unit of a small 8-bit accumulator-style core. Each cycle it may accept one operation. An operation takes the working register (W) value, a second operand, an operation code and the current status byte. The second operand is either a file-register value or an immediate literal. One clock later the block returns the result byte and a new status byte. In the new status byte, only the flags that the chosen operation is defined to touch have changed.

Each operation owns a fixed subset of the carry, digit-carry and zero flags. The status bits above the zero flag pass through unchanged. An extended-carry mode input decides whether add and subtract take the incoming carry into account. The instruction decoder, the register file and the write-back of the result are outside this block.

Top module: `byte_alu`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `res_valid` is 0, `result` is 0 and `status_out` is 0.
- R2: An operation presented with `op_valid` high appears on `result`/`status_out` with `res_valid` high after exactly one clock edge. When `op_valid` is low, `res_valid` goes low at the next edge and `result`/`status_out` keep their values.
- R3: Add (code 0) gives B + W, plus the status carry when `carry_ext` is 1. Carry (status bit 0) is the carry out of bit 7. Digit carry (bit 1) is the carry out of bit 3. Zero (bit 2) is set when the result is 0x00.
- R4: Subtract (code 1) gives B − W, and when `carry_ext` is 1 it also subtracts the inverse of the status carry. Carry is 1 exactly when no borrow occurs (B ≥ W + borrow-in). Digit carry is the same test on the low nibbles. Zero follows the result.
- R5: AND (2), OR (3) and XOR (4) combine W with B. Clear (5) gives 0x00. Increment (6) gives B+1, decrement (7) gives B−1, and complement (11) gives ~B. All of these update only zero and leave carry and digit carry unchanged.
- R6: Rotate left (8) gives {B[6:0], C} and rotate right (9) gives {C, B[7:1]}. The bit shifted out becomes the new carry. Digit carry and zero are unchanged.
- R7: Nibble swap (10) gives {B[3:0], B[7:4]} and changes no flag.
- R8: Status bits 7 down to 3 of `status_out` always equal those of `status_in` for that operation.
- R9: When `use_lit` is 1, operand B is `lit`; otherwise it is `f_opnd`.
- R10: Codes 12 to 15 are a test-move: the result is B and only zero is updated. Together with OR against a literal 0, this provides the zero test of a value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 4 | Operation code (see requirements) |
| carry_ext | input | 1 | Add/subtract include the incoming carry |
| use_lit | input | 1 | Select literal instead of file operand as B |
| w_opnd | input | 8 | Working register value W |
| f_opnd | input | 8 | File register operand |
| lit | input | 8 | Immediate literal operand |
| status_in | input | 8 | Current status byte (C bit 0, DC bit 1, Z bit 2) |
| res_valid | output | 1 | Result registered this cycle |
| result | output | 8 | Result byte |
| status_out | output | 8 | Updated status byte |

## Verification
The bench builds the block at its default 8-bit width, so every operand is one byte and the arithmetic reference is plain integer maths. At that width a grid of every operation code, both carry-mode settings and both carry-in values, crossed with a set of corner bytes on both operands (0x00, 0xFF, 0x0F, 0x80 and their neighbours), covers all nibble-carry and borrow boundaries. Random status bytes and operands then cover the mixing of pass-through status bits with the literal/file selection.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;
  localparam logic [3:0] OP_ADD  = 4'd0;
  localparam logic [3:0] OP_SUB  = 4'd1;
  localparam logic [3:0] OP_AND  = 4'd2;
  localparam logic [3:0] OP_OR   = 4'd3;
  localparam logic [3:0] OP_XOR  = 4'd4;
  localparam logic [3:0] OP_CLR  = 4'd5;
  localparam logic [3:0] OP_INC  = 4'd6;
  localparam logic [3:0] OP_DEC  = 4'd7;
  localparam logic [3:0] OP_RL   = 4'd8;
  localparam logic [3:0] OP_RR   = 4'd9;
  localparam logic [3:0] OP_SWAP = 4'd10;
  localparam logic [3:0] OP_NOT  = 4'd11;

  localparam int ST_C  = 0;
  localparam int ST_DC = 1;
  localparam int ST_Z  = 2;

  typedef struct packed {
    logic c;
    logic dc;
    logic z;
  } flag_upd_t;
endpackage

// File: rtl/byte_alu_addsub.sv
module byte_alu_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         do_sub,
  input  logic         use_cin,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         half_cout
);
  localparam int H  = W / 2;
  localparam int HU = W - H;

  logic         cin_eff;
  logic [W-1:0] b_eff;
  logic [H:0]   lo_sum;
  logic [HU:0]  hi_sum;

  // subtraction is a + ~b + 1, with the carry acting as inverted borrow
  assign cin_eff = use_cin ? cin : do_sub;
  assign b_eff   = do_sub ? ~b_in : b_in;
  assign lo_sum  = {1'b0, a_in[H-1:0]} + {1'b0, b_eff[H-1:0]} + {{H{1'b0}}, cin_eff};
  assign hi_sum  = {1'b0, a_in[W-1:H]} + {1'b0, b_eff[W-1:H]} + {{HU{1'b0}}, lo_sum[H]};

  assign sum       = {hi_sum[HU-1:0], lo_sum[H-1:0]};
  assign cout      = hi_sum[HU];
  assign half_cout = lo_sum[H];
endmodule

// File: rtl/byte_alu_unary.sv
module byte_alu_unary
  import byte_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] opnd,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         cout
);
  localparam int H = W / 2;

  always_comb begin
    cout = cin;
    case (op)
      OP_CLR:  res = '0;
      OP_INC:  res = opnd + W'(1);
      OP_DEC:  res = opnd - W'(1);
      OP_NOT:  res = ~opnd;
      OP_SWAP: res = {opnd[H-1:0], opnd[W-1:H]};
      OP_RL: begin
        res  = {opnd[W-2:0], cin};
        cout = opnd[W-1];
      end
      OP_RR: begin
        res  = {cin, opnd[W-1:1]};
        cout = opnd[0];
      end
      default: res = opnd;
    endcase
  end
endmodule

// File: rtl/byte_alu.sv
module byte_alu
  import byte_alu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ST_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [3:0]        op_code,
  input  logic              carry_ext,
  input  logic              use_lit,
  input  logic [DATA_W-1:0] w_opnd,
  input  logic [DATA_W-1:0] f_opnd,
  input  logic [DATA_W-1:0] lit,
  input  logic [ST_W-1:0]   status_in,
  output logic              res_valid,
  output logic [DATA_W-1:0] result,
  output logic [ST_W-1:0]   status_out
);
  logic [DATA_W-1:0] b_opnd;
  logic [DATA_W-1:0] as_sum, un_res, nxt_res;
  logic              as_cout, as_hcout, un_cout;
  logic              nxt_c, nxt_dc;
  flag_upd_t         upd;
  logic [ST_W-1:0]   nxt_st;
  logic [3:0]        r_op;

  assign b_opnd = use_lit ? lit : f_opnd;

  byte_alu_addsub #(.W(DATA_W)) u_addsub (
    .a_in      (b_opnd),
    .b_in      (w_opnd),
    .do_sub    (op_code == OP_SUB),
    .use_cin   (carry_ext),
    .cin       (status_in[ST_C]),
    .sum       (as_sum),
    .cout      (as_cout),
    .half_cout (as_hcout)
  );

  byte_alu_unary #(.W(DATA_W)) u_unary (
    .op   (op_code),
    .opnd (b_opnd),
    .cin  (status_in[ST_C]),
    .res  (un_res),
    .cout (un_cout)
  );

  always_comb begin
    nxt_res = un_res;
    nxt_c   = as_cout;
    nxt_dc  = as_hcout;
    upd     = '{c: 1'b0, dc: 1'b0, z: 1'b1};
    case (op_code)
      OP_ADD, OP_SUB: begin
        nxt_res = as_sum;
        upd     = '{c: 1'b1, dc: 1'b1, z: 1'b1};
      end
      OP_AND:  nxt_res = w_opnd & b_opnd;
      OP_OR:   nxt_res = w_opnd | b_opnd;
      OP_XOR:  nxt_res = w_opnd ^ b_opnd;
      OP_RL, OP_RR: begin
        nxt_c = un_cout;
        upd   = '{c: 1'b1, dc: 1'b0, z: 1'b0};
      end
      OP_SWAP: upd = '{c: 1'b0, dc: 1'b0, z: 1'b0};
      default: ;
    endcase
  end

  always_comb begin
    nxt_st = status_in;
    if (upd.c)  nxt_st[ST_C]  = nxt_c;
    if (upd.dc) nxt_st[ST_DC] = nxt_dc;
    if (upd.z)  nxt_st[ST_Z]  = (nxt_res == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid  <= 1'b0;
      result     <= '0;
      status_out <= '0;
      r_op       <= '0;
    end else begin
      res_valid <= op_valid;
      if (op_valid) begin
        result     <= nxt_res;
        status_out <= nxt_st;
        r_op       <= op_code;
      end
    end
  end

  // R2
  valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid == $past(op_valid));
  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> $stable(result) && $stable(status_out));
  // R8
  upper_status_chk: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> status_out[ST_W-1:3] == $past(status_in[ST_W-1:3]));
  // R7
  swap_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_SWAP) |=> status_out == $past(status_in));
  // R6
  rotate_keeps_zdc_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && (op_code == OP_RL || op_code == OP_RR))
      |=> status_out[ST_Z:ST_DC] == $past(status_in[ST_Z:ST_DC]));
  // R5
  zero_only_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && r_op >= OP_AND && r_op <= OP_DEC)
      |-> status_out[ST_Z] == (result == '0));
endmodule

// File: tb/byte_alu_bench.sv
module byte_alu_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       op_valid = 1'b0;
  logic [3:0] op_code = '0;
  logic       carry_ext = 1'b0;
  logic       use_lit = 1'b0;
  logic [7:0] w_opnd = '0, f_opnd = '0, lit = '0, status_in = '0;
  logic       res_valid;
  logic [7:0] result, status_out;

  int total = 0;
  int bad = 0;
  bit done = 0;
  int unsigned seed = 32'h1234_5678;

  byte_alu u_byte_alu (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .carry_ext(carry_ext), .use_lit(use_lit), .w_opnd(w_opnd),
    .f_opnd(f_opnd), .lit(lit), .status_in(status_in),
    .res_valid(res_valid), .result(result), .status_out(status_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int unsigned rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed >> 8;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model computed from the requirement text
  task automatic model(input int op, input int w, input int b, input int st,
                       input int ext, output int r, output int ost, output string tag);
    int c, bor, d, dl;
    c = st & 1;
    ost = st;
    r = 0;
    case (op)
      0: begin
        tag = "R3";
        d = b + w + (ext ? c : 0);
        r = d & 255;
        ost = (ost & ~3) | ((d >> 8) & 1) | ((((b & 15) + (w & 15) + (ext ? c : 0)) >> 4) << 1);
      end
      1: begin
        tag = "R4";
        bor = ext ? (1 - c) : 0;
        d  = b - w - bor;
        dl = (b & 15) - (w & 15) - bor;
        r = d & 255;
        ost = (ost & ~3) | (d >= 0 ? 1 : 0) | (dl >= 0 ? 2 : 0);
      end
      2: begin tag = "R5"; r = w & b; end
      3: begin tag = "R5"; r = w | b; end
      4: begin tag = "R5"; r = w ^ b; end
      5: begin tag = "R5"; r = 0; end
      6: begin tag = "R5"; r = (b + 1) & 255; end
      7: begin tag = "R5"; r = (b + 255) & 255; end
      8: begin tag = "R6"; r = ((b << 1) & 255) | c; ost = (ost & ~1) | (b >> 7); end
      9: begin tag = "R6"; r = (c << 7) | (b >> 1); ost = (ost & ~1) | (b & 1); end
      10: begin tag = "R7"; r = ((b & 15) << 4) | (b >> 4); end
      11: begin tag = "R5"; r = (~b) & 255; end
      default: begin tag = "R10"; r = b; end
    endcase
    if (op != 8 && op != 9 && op != 10)
      ost = (ost & ~4) | (r == 0 ? 4 : 0);
  endtask

  task automatic run_op(input int op, input int w, input int b, input int st,
                        input int ext, input bit lit_sel, input bit idle_chk);
    int er, est;
    string tag;
    int prev_r, prev_s;
    op_valid  = 1'b1;
    op_code   = 4'(op);
    carry_ext = ext[0];
    use_lit   = lit_sel;
    w_opnd    = 8'(w);
    status_in = 8'(st);
    if (lit_sel) begin lit = 8'(b); f_opnd = ~8'(b); end
    else begin f_opnd = 8'(b); lit = ~8'(b); end
    model(op, w, b, st, ext, er, est, tag);
    if (lit_sel) tag = {tag, "/R9"};
    @(negedge clk);
    check({tag, " result"}, result, er);
    check({tag, " status"}, status_out, est);
    check("R8 upper status", status_out[7:3], st >> 3);
    check("R2 valid", res_valid, 1);
    op_valid = 1'b0;
    if (idle_chk) begin
      prev_r = result;
      prev_s = status_out;
      op_code = 4'(rnd());
      w_opnd = 8'(rnd());
      f_opnd = 8'(rnd());
      status_in = 8'(rnd());
      @(negedge clk);
      check("R2 idle valid", res_valid, 0);
      check("R2 idle hold", {result, status_out}, {prev_r[7:0], prev_s[7:0]});
    end
  endtask

  initial begin
    int corner [8] = '{8'h00, 8'hFF, 8'h0F, 8'h80, 8'h01, 8'h7F, 8'hF0, 8'h10};
    repeat (3) @(negedge clk);
    check("R1 reset valid", res_valid, 0);
    check("R1 reset data", {result, status_out}, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset", {res_valid, result, status_out}, 0);
    for (int op = 0; op < 13; op++)
      for (int ext = 0; ext < 2; ext++)
        for (int ci = 0; ci < 2; ci++)
          for (int i = 0; i < 8; i++)
            for (int j = 0; j < 8; j++)
              run_op(op, corner[i], corner[j], (int'(rnd()) & 8'hF8) | (ci ? 1 : 0) | (j & 6),
                     ext, bit'((i + j) & 1), (i == j));
    for (int k = 0; k < 2000; k++)
      run_op(int'(rnd() & 15), int'(rnd() & 255), int'(rnd() & 255),
             int'(rnd() & 255), int'(rnd() & 1), bit'(rnd() & 1), (k % 7) == 0);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule